// File: doc/BRIEF.md
# Byte-Coded Accumulator Sequencer

This block is the control core of a very small 8-bit machine. It steps a program pointer through a 256-byte program store. For each instruction it reads one opcode byte and, when the byte asks for them, one or two operand bytes. It then carries the instruction out. It drives loads and stores to a banked data memory through a request port. It sends arithmetic, compare and bitwise work to an external ALU through a combinational port. It owns the working registers A, B and C, the bank selector M and the pointer P, and it stops for good on a halt instruction.

Each instruction byte carries three fields: an alternate-behaviour flag, an operand-follows bit and a 6-bit opcode. One opcode, when its flag is set, also carries a constant. That constant is loaded into A and written to memory in a single instruction. The program store and the data memory both answer one cycle after a request. The ALU answers within the same cycle.

Top module: `tiny_acc_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, P, A, B and C become 0, M becomes 1 (bank B) and `halted` becomes 0.
- R2: An instruction byte is split as follows: bit 7 is the flag, bit 6 is set when an address byte follows, and bits 5:0 are the opcode. An operand byte is fetched only when bit 6 is set; otherwise the operand is 0. When no jump is taken, P advances by 1 + bit 6 (+1 more for a constant-carrying store), modulo 256.
- R3: Opcodes 0 and 1 load A or B from data memory at the operand address in bank M. Opcodes 2, 3 and 4 store A, B or C there.
- R4: The ALU result is written to C for opcodes 5 (add, `alu_sel`=0), 6 (A minus B, `alu_sel`=1), 12 (A equal to B, `alu_sel`=2) and 13 (A below B, `alu_sel`=3). It is written to A for opcodes 14, 15 and 16 (AND, OR, XOR, `alu_sel`=4, 5, 6). `alu_flip` carries the flag bit, and the ALU inverts the 0/1 result of the two compares with it.
- R5: Opcode 7 loads P with the operand. Opcode 8 does so only when C is nonzero, and opcode 9 only when C is zero.
- R6: Opcode 11 with the flag clear acts exactly as opcode 2. With the flag set, the address byte is followed by a constant byte. That constant is loaded into A and written to the address.
- R7: Opcode 17 stops the machine: `halted` rises and stays high until reset, P keeps the address of the halt byte, and neither `rom_req` nor `mem_req` is raised again.
- R8: A byte fetched as an instruction from location 255 is executed as a halt, whatever it holds.
- R9: Opcode 18 sets M to the low two bits of its operand (bank A=0, B=1, C=2, D=3). All loads and stores present M on `mem_bank`. A bank change alters neither C nor P beyond the normal advance.
- R10: Opcode 10 and every opcode from 19 to 63 changes no register other than P and makes no memory request.
- R11: The flag bit is ignored by every opcode except 11, 12 and 13.
- R12: `mem_req` is raised once per load or store and never otherwise. `mem_we` is high only together with `mem_req` and only for stores. Program and data requests never share a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rom_req | output | 1 | Program-store read request |
| rom_addr | output | 8 | Program-store address |
| rom_data | input | 8 | Program byte, valid the cycle after the request |
| mem_req | output | 1 | Data-memory request |
| mem_we | output | 1 | Data-memory write enable |
| mem_bank | output | 2 | Selected bank (M) |
| mem_addr | output | 8 | Data-memory address |
| mem_wdata | output | 8 | Data to write |
| mem_rdata | input | 8 | Read data, valid the cycle after a read request |
| alu_sel | output | 3 | ALU function code |
| alu_flip | output | 1 | Inverts compare results |
| alu_x | output | 8 | ALU left operand (A) |
| alu_y | output | 8 | ALU right operand (B) |
| alu_res | input | 8 | ALU result, same cycle |
| halted | output | 1 | Machine has stopped |
| p_out | output | 8 | Program pointer |
| a_out | output | 8 | Register A |
| b_out | output | 8 | Register B |
| c_out | output | 8 | Register C |
| m_out | output | 2 | Bank register |

## Verification
The bench targets five weak spots. The first is the three-byte constant store: a design that miscounted its bytes would land P one place off and then execute the constant as code. Conditional jumps are run both taken and not taken, with targets placed so that a wrong choice leaves a different P or loops until the per-program timeout. The forced halt at location 255 gets its own test, because a design that executed the real byte there would wrap to 0 and spin. A separate program places an operand byte at 255 and expects P to wrap past it to 0, which catches a design that applies the forced halt to operand reads. Unassigned opcodes with and without the flag and the operand bit must skip the correct number of bytes and issue no memory request. A bank switch must steer a later load and store.

// File: rtl/tacs_pkg.sv
// Shared opcode numbers and internal types of the accumulator sequencer.
// Assumes an 8-bit instruction byte with a 6-bit opcode field.
package tacs_pkg;

    localparam logic [5:0] OP_LDA = 6'd0;
    localparam logic [5:0] OP_LDB = 6'd1;
    localparam logic [5:0] OP_STA = 6'd2;
    localparam logic [5:0] OP_STB = 6'd3;
    localparam logic [5:0] OP_STC = 6'd4;
    localparam logic [5:0] OP_ADD = 6'd5;
    localparam logic [5:0] OP_SUB = 6'd6;
    localparam logic [5:0] OP_JMP = 6'd7;
    localparam logic [5:0] OP_JNZ = 6'd8;
    localparam logic [5:0] OP_JZ  = 6'd9;
    localparam logic [5:0] OP_NOP = 6'd10;
    localparam logic [5:0] OP_SET = 6'd11;
    localparam logic [5:0] OP_CMP = 6'd12;
    localparam logic [5:0] OP_CPL = 6'd13;
    localparam logic [5:0] OP_AND = 6'd14;
    localparam logic [5:0] OP_OR  = 6'd15;
    localparam logic [5:0] OP_XOR = 6'd16;
    localparam logic [5:0] OP_HLT = 6'd17;
    localparam logic [5:0] OP_BNK = 6'd18;

    typedef enum logic [3:0] {
        K_NOP, K_LDA, K_LDB, K_STA, K_STB, K_STC, K_ALUC, K_ALUA,
        K_JMP, K_JNZ, K_JZ, K_SETK, K_HLT, K_BNK
    } kind_e;

    typedef enum logic [2:0] {
        ALU_ADD = 3'd0, ALU_SUB = 3'd1, ALU_EQ = 3'd2, ALU_LT = 3'd3,
        ALU_AND = 3'd4, ALU_OR = 3'd5, ALU_XOR = 3'd6
    } alu_e;

    typedef struct packed {
        kind_e kind;
        alu_e  alu;
        logic  flag;
        logic  has_addr;
        logic  has_const;
    } dec_t;

    typedef enum logic [2:0] {
        S_FETCH, S_INSTR, S_OPA, S_OPC, S_EXEC, S_LDW, S_HALT
    } state_e;

endpackage

// File: rtl/tacs_decode.sv
// Instruction decoder: splits a byte into flag, operand-follows bit and
// opcode and maps the opcode to an action class and an ALU function.
// Assumes DW >= 3. A byte fetched from the last program location is
// forced to halt. Unassigned opcodes decode as no-operation.
module tacs_decode
    import tacs_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0] ins,
    input  logic          at_last,
    output dec_t          dec
);
    localparam int OW = DW - 2;

    logic [OW-1:0] opc;
    assign opc = ins[OW-1:0];

    // Map the opcode field to an action, then apply the last-location override.
    always_comb begin
        dec           = '0;
        dec.kind      = K_NOP;
        dec.alu       = ALU_ADD;
        dec.flag      = ins[DW-1];
        dec.has_addr  = ins[DW-2];
        dec.has_const = 1'b0;
        case (opc)
            OW'(OP_LDA): dec.kind = K_LDA;
            OW'(OP_LDB): dec.kind = K_LDB;
            OW'(OP_STA): dec.kind = K_STA;
            OW'(OP_STB): dec.kind = K_STB;
            OW'(OP_STC): dec.kind = K_STC;
            OW'(OP_ADD): begin dec.kind = K_ALUC; dec.alu = ALU_ADD; end
            OW'(OP_SUB): begin dec.kind = K_ALUC; dec.alu = ALU_SUB; end
            OW'(OP_JMP): dec.kind = K_JMP;
            OW'(OP_JNZ): dec.kind = K_JNZ;
            OW'(OP_JZ):  dec.kind = K_JZ;
            OW'(OP_NOP): dec.kind = K_NOP;
            OW'(OP_SET): begin
                dec.kind      = ins[DW-1] ? K_SETK : K_STA;
                dec.has_const = ins[DW-1];
            end
            OW'(OP_CMP): begin dec.kind = K_ALUC; dec.alu = ALU_EQ;  end
            OW'(OP_CPL): begin dec.kind = K_ALUC; dec.alu = ALU_LT;  end
            OW'(OP_AND): begin dec.kind = K_ALUA; dec.alu = ALU_AND; end
            OW'(OP_OR):  begin dec.kind = K_ALUA; dec.alu = ALU_OR;  end
            OW'(OP_XOR): begin dec.kind = K_ALUA; dec.alu = ALU_XOR; end
            OW'(OP_HLT): dec.kind = K_HLT;
            OW'(OP_BNK): dec.kind = K_BNK;
            default:     dec.kind = K_NOP;
        endcase
        if (at_last) begin
            dec.kind      = K_HLT;
            dec.has_addr  = 1'b0;
            dec.has_const = 1'b0;
        end
    end

endmodule

// File: rtl/tacs_regs.sv
// Working registers: A, B and C (index 0, 1, 2) of DW bits each, plus the
// BW-bit bank register. One write enable per register. Synchronous
// active-low reset: data registers clear, bank loads RESET_BANK.
module tacs_regs #(
    parameter int              DW         = 8,
    parameter int              BW         = 2,
    parameter int              NREG       = 3,
    parameter logic [BW-1:0]   RESET_BANK = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NREG-1:0]          we,
    input  logic [NREG-1:0][DW-1:0]  d,
    input  logic                     we_m,
    input  logic [BW-1:0]            d_m,
    output logic [NREG-1:0][DW-1:0]  q,
    output logic [BW-1:0]            q_m
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        // Hold or update one data register.
        always_ff @(posedge clk) begin
            if (!rst_n)     q[g] <= '0;
            else if (we[g]) q[g] <= d[g];
        end
    end

    // Hold or update the bank selector.
    always_ff @(posedge clk) begin
        if (!rst_n)    q_m <= RESET_BANK;
        else if (we_m) q_m <= d_m;
    end

endmodule

// File: rtl/tacs_nextp.sv
// Next program pointer: sequential advance by the instruction length
// (1 + address byte + constant byte, wrapping modulo 2**AW) or a jump
// target when the jump condition on C holds.
module tacs_nextp #(
    parameter int AW = 8
) (
    input  logic [AW-1:0] p,
    input  logic          has_addr,
    input  logic          has_const,
    input  logic          is_jmp,
    input  logic          is_jnz,
    input  logic          is_jz,
    input  logic          c_zero,
    input  logic [AW-1:0] target,
    output logic [AW-1:0] p_next
);
    logic [AW-1:0] seq;
    logic          taken;

    // Choose between the wrapped sequential address and the jump target.
    always_comb begin
        seq    = p + AW'(1) + AW'(has_addr) + AW'(has_const);
        taken  = is_jmp | (is_jnz & ~c_zero) | (is_jz & c_zero);
        p_next = taken ? target : seq;
    end

endmodule

// File: rtl/tiny_acc_seq.sv
// Fetch, decode and execute controller of a small 8-bit accumulator machine.
// Program store and data memory return data one cycle after a request. The
// ALU is combinational. Assumes AW == DW (operands double as addresses).
module tiny_acc_seq
    import tacs_pkg::*;
#(
    parameter int            DW         = 8,
    parameter int            AW         = 8,
    parameter int            BW         = 2,
    parameter logic [BW-1:0] RESET_BANK = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          rom_req,
    output logic [AW-1:0] rom_addr,
    input  logic [DW-1:0] rom_data,
    output logic          mem_req,
    output logic          mem_we,
    output logic [BW-1:0] mem_bank,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic [2:0]    alu_sel,
    output logic          alu_flip,
    output logic [DW-1:0] alu_x,
    output logic [DW-1:0] alu_y,
    input  logic [DW-1:0] alu_res,
    output logic          halted,
    output logic [AW-1:0] p_out,
    output logic [DW-1:0] a_out,
    output logic [DW-1:0] b_out,
    output logic [DW-1:0] c_out,
    output logic [BW-1:0] m_out
);
    localparam int            NREG     = 3;
    localparam logic [AW-1:0] LAST_LOC = '1;

    state_e                   state_q, state_d;
    logic [AW-1:0]            p_q, p_d, p_next;
    dec_t                     dec_now, dec_q;
    logic [DW-1:0]            opa_q, opk_q;
    logic [NREG-1:0]          we;
    logic [NREG-1:0][DW-1:0]  d, q;
    logic                     we_m;
    logic [BW-1:0]            m_q;

    tacs_decode #(.DW(DW)) u_dec (
        .ins     (rom_data),
        .at_last (p_q == LAST_LOC),
        .dec     (dec_now)
    );

    tacs_regs #(.DW(DW), .BW(BW), .NREG(NREG), .RESET_BANK(RESET_BANK)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we),
        .d     (d),
        .we_m  (we_m),
        .d_m   (opa_q[BW-1:0]),
        .q     (q),
        .q_m   (m_q)
    );

    tacs_nextp #(.AW(AW)) u_nextp (
        .p         (p_q),
        .has_addr  (dec_q.has_addr),
        .has_const (dec_q.has_const),
        .is_jmp    (dec_q.kind == K_JMP),
        .is_jnz    (dec_q.kind == K_JNZ),
        .is_jz     (dec_q.kind == K_JZ),
        .c_zero    (q[2] == '0),
        .target    (AW'(opa_q)),
        .p_next    (p_next)
    );

    assign mem_bank = m_q;
    assign alu_x    = q[0];
    assign alu_y    = q[1];
    assign alu_sel  = dec_q.alu;
    assign alu_flip = dec_q.flag;
    assign halted   = (state_q == S_HALT);
    assign p_out    = p_q;
    assign a_out    = q[0];
    assign b_out    = q[1];
    assign c_out    = q[2];
    assign m_out    = m_q;

    // Sequence the phases and drive requests and register writes.
    always_comb begin
        state_d   = state_q;
        p_d       = p_q;
        rom_req   = 1'b0;
        rom_addr  = p_q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = AW'(opa_q);
        mem_wdata = '0;
        we        = '0;
        d         = '0;
        we_m      = 1'b0;
        case (state_q)
            S_FETCH: begin
                rom_req = 1'b1;
                state_d = S_INSTR;
            end
            S_INSTR: begin
                if (dec_now.kind == K_HLT) begin
                    state_d = S_HALT;
                end else if (dec_now.has_addr || dec_now.has_const) begin
                    rom_req  = 1'b1;
                    rom_addr = p_q + AW'(1);
                    state_d  = dec_now.has_addr ? S_OPA : S_OPC;
                end else begin
                    state_d = S_EXEC;
                end
            end
            S_OPA: begin
                if (dec_q.has_const) begin
                    rom_req  = 1'b1;
                    rom_addr = p_q + AW'(2);
                    state_d  = S_OPC;
                end else begin
                    state_d = S_EXEC;
                end
            end
            S_OPC: state_d = S_EXEC;
            S_EXEC: begin
                p_d     = p_next;
                state_d = S_FETCH;
                case (dec_q.kind)
                    K_LDA, K_LDB: begin
                        mem_req = 1'b1;
                        state_d = S_LDW;
                    end
                    K_STA: begin mem_req = 1'b1; mem_we = 1'b1; mem_wdata = q[0]; end
                    K_STB: begin mem_req = 1'b1; mem_we = 1'b1; mem_wdata = q[1]; end
                    K_STC: begin mem_req = 1'b1; mem_we = 1'b1; mem_wdata = q[2]; end
                    K_SETK: begin
                        we[0]     = 1'b1;
                        d[0]      = opk_q;
                        mem_req   = 1'b1;
                        mem_we    = 1'b1;
                        mem_wdata = opk_q;
                    end
                    K_ALUC: begin we[2] = 1'b1; d[2] = alu_res; end
                    K_ALUA: begin we[0] = 1'b1; d[0] = alu_res; end
                    K_BNK:  we_m = 1'b1;
                    default: ;
                endcase
            end
            S_LDW: begin
                if (dec_q.kind == K_LDA) begin
                    we[0] = 1'b1;
                    d[0]  = mem_rdata;
                end else begin
                    we[1] = 1'b1;
                    d[1]  = mem_rdata;
                end
                state_d = S_FETCH;
            end
            S_HALT: state_d = S_HALT;
            default: state_d = S_FETCH;
        endcase
    end

    // Register phase, pointer, latched decode and operand bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_FETCH;
            p_q     <= '0;
            dec_q   <= '0;
            opa_q   <= '0;
            opk_q   <= '0;
        end else begin
            state_q <= state_d;
            p_q     <= p_d;
            if (state_q == S_INSTR) begin
                dec_q <= dec_now;
                opa_q <= '0;
                opk_q <= '0;
            end
            if (state_q == S_OPA) opa_q <= rom_data;
            if (state_q == S_OPC) opk_q <= rom_data;
        end
    end

endmodule

// File: rtl/tacs_checker.sv
// Temporal checks on the sequencer's ports, attached by bind.
module tacs_checker #(
    parameter int AW = 8,
    parameter int DW = 8,
    parameter int BW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rom_req,
    input logic          mem_req,
    input logic          mem_we,
    input logic [BW-1:0] mem_bank,
    input logic          halted,
    input logic [AW-1:0] p_out,
    input logic [DW-1:0] a_out,
    input logic [DW-1:0] b_out,
    input logic [DW-1:0] c_out,
    input logic [BW-1:0] m_out
);
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (p_out == '0 && a_out == '0 && b_out == '0 && c_out == '0
                    && m_out == BW'(1) && !halted));

    assert_halt_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    assert_halt_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!rom_req && !mem_req));

    assert_halt_p_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(p_out));

    assert_we_needs_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req);

    assert_bus_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(rom_req && mem_req));

    assert_bank_on_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_bank == m_out));

    assert_bank_keeps_c_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (m_out != $past(m_out)) |-> (c_out == $past(c_out) && !$past(mem_req)));

endmodule

bind tiny_acc_seq tacs_checker #(.AW(AW), .DW(DW), .BW(BW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rom_req  (rom_req),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_bank (mem_bank),
    .halted   (halted),
    .p_out    (p_out),
    .a_out    (a_out),
    .b_out    (b_out),
    .c_out    (c_out),
    .m_out    (m_out)
);

// File: tb/tiny_acc_seq_tb_top.sv
// Bench: program-store, data-memory and ALU models around the sequencer, a
// vector table of short programs, then directed tests.
module tiny_acc_seq_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mem_clear = 1'b0;
    logic       rom_req, mem_req, mem_we, alu_flip, halted;
    logic [7:0] rom_addr, rom_data, mem_addr, mem_wdata, mem_rdata;
    logic [1:0] mem_bank, m_out;
    logic [2:0] alu_sel;
    logic [7:0] alu_x, alu_y, alu_res, p_out, a_out, b_out, c_out;
    logic [7:0] img [256];
    logic [7:0] dmem [4][256];
    int         n_cmp = 0;
    int         n_bad = 0;

    always #10 clk = ~clk;

    tiny_acc_seq dut_i (
        .clk(clk), .rst_n(rst_n),
        .rom_req(rom_req), .rom_addr(rom_addr), .rom_data(rom_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_bank(mem_bank),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .alu_sel(alu_sel), .alu_flip(alu_flip), .alu_x(alu_x), .alu_y(alu_y),
        .alu_res(alu_res), .halted(halted), .p_out(p_out), .a_out(a_out),
        .b_out(b_out), .c_out(c_out), .m_out(m_out)
    );

    function automatic logic [7:0] init_val(input int b, input int i);
        return 8'((b * 37 + i * 3 + 5) & 255);
    endfunction

    // Program store: one-cycle read latency.
    always @(posedge clk) if (rom_req) rom_data <= img[rom_addr];

    // Data memory: cleared to a known pattern on request, one-cycle reads.
    always @(posedge clk) begin
        if (mem_clear) begin
            for (int b = 0; b < 4; b++)
                for (int i = 0; i < 256; i++) dmem[b][i] <= init_val(b, i);
        end else if (mem_req) begin
            if (mem_we) dmem[mem_bank][mem_addr] <= mem_wdata;
            else        mem_rdata <= dmem[mem_bank][mem_addr];
        end
    end

    // ALU model following R4.
    always_comb begin
        case (alu_sel)
            3'd0:    alu_res = alu_x + alu_y;
            3'd1:    alu_res = alu_x - alu_y;
            3'd2:    alu_res = {7'd0, (alu_x == alu_y) ^ alu_flip};
            3'd3:    alu_res = {7'd0, (alu_x < alu_y) ^ alu_flip};
            3'd4:    alu_res = alu_x & alu_y;
            3'd5:    alu_res = alu_x | alu_y;
            3'd6:    alu_res = alu_x ^ alu_y;
            default: alu_res = 8'd0;
        endcase
    end

    typedef struct packed {
        logic [63:0] prog;
        logic [7:0]  ea, eb, ec, ep;
        logic [1:0]  em, cb;
        logic [7:0]  ca, cv;
        logic [3:0]  nreq;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{64'h4010_4111_0544_3011, 8'h5A, 8'h5D, 8'hB7, 8'h07, 2'd1, 2'd1, 8'h30, 8'hB7, 4'd3}, // R3 R4 add, store C
        '{64'h4010_4111_0611_1111, 8'h5A, 8'h5D, 8'hFD, 8'h05, 2'd1, 2'd1, 8'h30, 8'hBA, 4'd2}, // R4 subtract wraps
        '{64'hCB20_7E41_2011_1111, 8'h7E, 8'h7E, 8'h00, 8'h05, 2'd1, 2'd1, 8'h20, 8'h7E, 4'd2}, // R6 constant store
        '{64'hCB21_334B_2211_1111, 8'h33, 8'h00, 8'h00, 8'h05, 2'd1, 2'd1, 8'h22, 8'h33, 4'd2}, // R6 flag clear = store A
        '{64'hCB20_0541_208D_1111, 8'h05, 8'h05, 8'h01, 8'h06, 2'd1, 2'd1, 8'h20, 8'h05, 4'd2}, // R4 below, flipped
        '{64'hCB20_058C_1111_1111, 8'h05, 8'h00, 8'h01, 8'h04, 2'd1, 2'd1, 8'h20, 8'h05, 4'd1}, // R4 equal, flipped
        '{64'hCB20_0F41_1010_1111, 8'h55, 8'h5A, 8'h00, 8'h06, 2'd1, 2'd1, 8'h20, 8'h0F, 4'd2}, // R4 XOR into A
        '{64'h4704_1111_4807_1111, 8'h00, 8'h00, 8'h00, 8'h06, 2'd1, 2'd1, 8'h30, 8'hBA, 4'd0}, // R5 jump, nonzero test not taken
        '{64'h4905_1111_1111_1111, 8'h00, 8'h00, 8'h00, 8'h05, 2'd1, 2'd1, 8'h30, 8'hBA, 4'd0}, // R5 zero test taken
        '{64'hCB20_0141_2005_4820, 8'h01, 8'h01, 8'h02, 8'h20, 2'd1, 2'd1, 8'h20, 8'h01, 4'd2}, // R5 nonzero test taken
        '{64'h5202_4010_4230_1111, 8'h7F, 8'h00, 8'h00, 8'h06, 2'd2, 2'd2, 8'h30, 8'h7F, 4'd2}, // R9 bank switch
        '{64'h0A93_7F55_3F11_1111, 8'h00, 8'h00, 8'h00, 8'h05, 2'd1, 2'd1, 8'h30, 8'hBA, 4'd0}, // R10 R11 no-ops
        '{64'hCB20_0141_2005_C900, 8'h01, 8'h01, 8'h02, 8'h08, 2'd1, 2'd1, 8'h20, 8'h01, 4'd2}, // R11 flag on zero test
        '{64'h4111_4340_1111_1111, 8'h00, 8'h5D, 8'h00, 8'h04, 2'd1, 2'd1, 8'h40, 8'h5D, 4'd2}  // R3 load/store B
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic boot();
        @(negedge clk);
        rst_n     = 1'b0;
        mem_clear = 1'b1;
        repeat (3) @(negedge clk);
        mem_clear = 1'b0;
        rst_n     = 1'b1;
    endtask

    task automatic run(output bit done, output int nreq);
        done = 1'b0;
        nreq = 0;
        for (int i = 0; i < 800; i++) begin
            @(negedge clk);
            if (halted) begin
                done = 1'b1;
                return;
            end
            if (mem_req) nreq++;
        end
    endtask

    task automatic after_halt_quiet();
        int fetches = 0;
        logic [7:0] p0 = p_out;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (rom_req || mem_req) fetches++;
        end
        check("R7 requests after halt", 32'(fetches), 32'd0);
        check("R7 halted stays high", {31'd0, halted}, 32'd1);
        check("R7 P frozen", {24'd0, p_out}, {24'd0, p0});
    endtask

    initial begin
        bit done;
        int nreq;
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual expired expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        bit done;
        int nreq;
        // Vector table of short programs.
        for (int v = 0; v < NV; v++) begin
            for (int k = 0; k < 256; k++) img[k] = 8'h11;
            for (int k = 0; k < 8; k++) img[k] = VECS[v].prog[63 - 8*k -: 8];
            boot();
            run(done, nreq);
            check($sformatf("R7 vec %0d halted", v), {31'd0, done}, 32'd1);
            check($sformatf("R3/R4/R6 vec %0d reg A", v), {24'd0, a_out}, {24'd0, VECS[v].ea});
            check($sformatf("R3 vec %0d reg B", v), {24'd0, b_out}, {24'd0, VECS[v].eb});
            check($sformatf("R4 vec %0d reg C", v), {24'd0, c_out}, {24'd0, VECS[v].ec});
            check($sformatf("R2/R5/R10/R11 vec %0d P", v), {24'd0, p_out}, {24'd0, VECS[v].ep});
            check($sformatf("R9 vec %0d bank", v), {30'd0, m_out}, {30'd0, VECS[v].em});
            check($sformatf("R3/R6 vec %0d memory", v),
                  {24'd0, dmem[VECS[v].cb][VECS[v].ca]}, {24'd0, VECS[v].cv});
            check($sformatf("R12 vec %0d data requests", v), 32'(nreq), {28'd0, VECS[v].nreq});
            if (v == 0) after_halt_quiet();
        end

        // R1: reset after a run with nonzero registers.
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 P", {24'd0, p_out}, 32'd0);
        check("R1 A", {24'd0, a_out}, 32'd0);
        check("R1 B", {24'd0, b_out}, 32'd0);
        check("R1 C", {24'd0, c_out}, 32'd0);
        check("R1 bank", {30'd0, m_out}, 32'd1);
        check("R1 halted", {31'd0, halted}, 32'd0);

        // R8: location 255 holds a no-op but must halt.
        for (int k = 0; k < 256; k++) img[k] = 8'h0A;
        img[0] = 8'h47;
        img[1] = 8'hFF;
        boot();
        run(done, nreq);
        check("R8 halted at last location", {31'd0, done}, 32'd1);
        check("R8 P", {24'd0, p_out}, 32'hFF);

        // R2 wrap, R9 bank from an operand read at location 255.
        for (int k = 0; k < 256; k++) img[k] = 8'h11;
        img[0] = 8'h48; img[1] = 8'h10;
        img[2] = 8'hCB; img[3] = 8'h20; img[4] = 8'h01;
        img[5] = 8'h47; img[6] = 8'hFD;
        img[253] = 8'h05;
        img[254] = 8'h52; img[255] = 8'h03;
        boot();
        run(done, nreq);
        check("R2 wrap halted", {31'd0, done}, 32'd1);
        check("R2 wrap P", {24'd0, p_out}, 32'h10);
        check("R9 wrap bank", {30'd0, m_out}, 32'd3);
        check("R4 wrap C", {24'd0, c_out}, 32'd1);
        after_halt_quiet();

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule